// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry from memory, then a page table entry, and joins the page frame number it finds with the page offset. The directory base comes from a 32-bit control value whose upper 20 bits locate a page-aligned directory. Its low 12 bits play no part in the address.

A translation begins when a one-cycle request strobe is seen while the walker is idle. The walker samples the linear address and the directory base at that edge. It then uses a single memory read port, with at most one read in flight. A read is held until the memory returns a valid word. An entry whose present bit (bit 0) is clear ends the walk with a page fault. The faulting linear address is then written into a fault-address register, which holds its value until the next fault. Each request may carry a different directory base, so the walker can follow a context switch between walks.

Top module: `pgwalk`

## Requirements
- R1: After reset the memory read request, done and fault are low, and the physical-address and fault-address outputs are zero.
- R2: The first read goes to the address formed by the directory base bits 31:12 followed by twelve zero bits, plus four times the linear address bits 31:22. The directory base bits 11:0 are ignored.
- R3: The second read goes to the address formed by the directory entry bits 31:12, then the linear address bits 21:12, then two zero bits.
- R4: When both entries have bit 0 set, the physical-address output becomes the table entry bits 31:12 joined with linear address bits 11:0. Done pulses high for exactly one cycle, in the cycle after the edge that accepts the second read data, and fault stays low.
- R5: A directory entry with bit 0 clear ends the walk without a second read. Done and fault pulse together for one cycle, in the cycle after the edge that accepts the data, and the fault-address output becomes the request's linear address.
- R6: A table entry with bit 0 clear ends the walk with the same fault pulse, and the fault address is captured as in R5.
- R7: The fault-address output changes only when a fault is reported. The physical-address output changes only when a successful walk completes.
- R8: Only one read is outstanding at a time. The read request stays high with a stable address until read data is flagged valid, and it is low while done is high.
- R9: A request strobe seen during a walk is ignored. Changes to the linear address or the directory base after the accepting edge have no effect on the walk.
- R10: Each new request uses the directory base presented with it. Consecutive walks through different bases read from different directories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a translation (sampled only when idle) |
| lin_addr_i | input | 32 | Linear address to translate |
| dir_base_i | input | 32 | Directory base control value; bits 11:0 ignored |
| mem_rd_o | output | 1 | Memory read request, held until data is valid |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| phys_addr_o | output | 32 | Result of the last successful translation |
| done_o | output | 1 | One-cycle pulse when a walk ends |
| fault_o | output | 1 | One-cycle pulse with done when the walk faulted |
| fault_addr_o | output | 32 | Linear address of the last faulting walk |

## Verification
The read request rises in the cycle after the accepting edge, and the read address is due then. The second read is due in the cycle after the edge that takes the first valid word. Done, fault and the result registers are due in the cycle after the edge that takes the last word needed. The bench's reference model advances on the same rising edges as the design, using only the port inputs. All outputs are compared at the falling edge, so every result is checked in exactly the cycle it is due. The memory responder is run at latencies of zero, one and three cycles, which moves the due cycles. The timing is therefore checked as a relation to the read-valid handshake, not as a fixed count.

// File: rtl/pgwalk_pkg.sv
// Shared types for the two-level page walker.
// Assumes: nothing beyond the package itself.
package pgwalk_pkg;

    // walk sequencer states
    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_RD_DIR = 3'd1,
        WS_RD_TBL = 3'd2,
        WS_OK     = 3'd3,
        WS_FLT    = 3'd4
    } walk_st_e;

    // log2 of the entry size in bytes (32-bit entries)
    localparam int unsigned ENT_SH = 2;

endpackage

// File: rtl/pgwalk_split.sv
// Splits a linear address into directory index, table index and page offset.
// Assumes: AW = DIR_W + TBL_W + offset width, with the offset in the low bits.
module pgwalk_split #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DIR_W = 10,
    parameter int unsigned TBL_W = 10
) (
    input  logic [AW-1:0]              lin_i,
    output logic [DIR_W-1:0]           dir_idx_o,
    output logic [TBL_W-1:0]           tbl_idx_o,
    output logic [AW-DIR_W-TBL_W-1:0]  off_o
);
    localparam int unsigned OFF_W = AW - DIR_W - TBL_W;

    // field extraction
    always_comb begin
        dir_idx_o = lin_i[AW-1 -: DIR_W];
        tbl_idx_o = lin_i[OFF_W +: TBL_W];
        off_o     = lin_i[OFF_W-1:0];
    end
endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer: idle, directory read, table read, then a one-cycle
// success or fault state. Issues one read at a time and holds it until
// the memory flags valid data.
// Assumes: present_i is bit 0 of the returned entry, valid with rvalid_i.
module pgwalk_ctrl
    import pgwalk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rvalid_i,
    input  logic present_i,
    output logic rd_o,
    output logic sel_tbl_o,
    output logic done_o,
    output logic fault_o,
    output logic cap_req_o,
    output logic cap_pde_o,
    output logic cap_pte_o,
    output logic cap_flt_o
);
    walk_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    // next state and capture strobes
    always_comb begin
        st_d      = st_q;
        cap_req_o = 1'b0;
        cap_pde_o = 1'b0;
        cap_pte_o = 1'b0;
        cap_flt_o = 1'b0;
        unique case (st_q)
            WS_IDLE: begin
                if (req_i) begin
                    st_d      = WS_RD_DIR;
                    cap_req_o = 1'b1;
                end
            end
            WS_RD_DIR: begin
                if (rvalid_i) begin
                    if (present_i) begin
                        st_d      = WS_RD_TBL;
                        cap_pde_o = 1'b1;
                    end else begin
                        st_d      = WS_FLT;
                        cap_flt_o = 1'b1;
                    end
                end
            end
            WS_RD_TBL: begin
                if (rvalid_i) begin
                    if (present_i) begin
                        st_d      = WS_OK;
                        cap_pte_o = 1'b1;
                    end else begin
                        st_d      = WS_FLT;
                        cap_flt_o = 1'b1;
                    end
                end
            end
            WS_OK:   st_d = WS_IDLE;
            WS_FLT:  st_d = WS_IDLE;
            default: st_d = WS_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        rd_o      = (st_q == WS_RD_DIR) || (st_q == WS_RD_TBL);
        sel_tbl_o = (st_q == WS_RD_TBL);
        done_o    = (st_q == WS_OK) || (st_q == WS_FLT);
        fault_o   = (st_q == WS_FLT);
    end
endmodule

// File: rtl/pgwalk_dpath.sv
// Walk datapath: holds the request, forms entry addresses, and keeps the
// translated address and the faulting address.
// Assumes: capture strobes come from the sequencer and are mutually exclusive.
module pgwalk_dpath
    import pgwalk_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DIR_W = 10,
    parameter int unsigned TBL_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lin_i,
    input  logic [AW-1:0] dir_base_i,
    input  logic [AW-1:0] entry_i,
    input  logic          sel_tbl_i,
    input  logic          cap_req_i,
    input  logic          cap_pde_i,
    input  logic          cap_pte_i,
    input  logic          cap_flt_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [AW-1:0] phys_o,
    output logic [AW-1:0] flt_addr_o
);
    localparam int unsigned OFF_W = AW - DIR_W - TBL_W;
    localparam int unsigned FRM_W = AW - OFF_W;

    logic [AW-1:0]    la_q;
    logic [FRM_W-1:0] dir_frm_q;
    logic [FRM_W-1:0] tbl_frm_q;
    logic [AW-1:0]    phys_q;
    logic [AW-1:0]    flt_q;

    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;
    logic [OFF_W-1:0] pg_off;
    logic [AW-1:0]    dir_ent_addr;
    logic [AW-1:0]    tbl_ent_addr;
    logic             base_low_unused;
    logic             entry_attr_unused;

    pgwalk_split #(.AW(AW), .DIR_W(DIR_W), .TBL_W(TBL_W)) u_split (
        .lin_i     (la_q),
        .dir_idx_o (dir_idx),
        .tbl_idx_o (tbl_idx),
        .off_o     (pg_off)
    );

    // bits that carry no meaning for the walk
    assign base_low_unused   = ^dir_base_i[OFF_W-1:0];
    assign entry_attr_unused = ^entry_i[OFF_W-1:1];

    // entry address formation for both levels
    always_comb begin
        dir_ent_addr = {dir_frm_q, {OFF_W{1'b0}}}
                     + {{(AW-DIR_W-ENT_SH){1'b0}}, dir_idx, {ENT_SH{1'b0}}};
        tbl_ent_addr = {tbl_frm_q, {OFF_W{1'b0}}}
                     + {{(AW-TBL_W-ENT_SH){1'b0}}, tbl_idx, {ENT_SH{1'b0}}};
        mem_addr_o   = sel_tbl_i ? tbl_ent_addr : dir_ent_addr;
    end

    // request capture: linear address and page-aligned directory frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q      <= '0;
            dir_frm_q <= '0;
        end else if (cap_req_i) begin
            la_q      <= lin_i;
            dir_frm_q <= dir_base_i[AW-1:OFF_W];
        end
    end

    // table frame from a present directory entry
    always_ff @(posedge clk) begin
        if (!rst_n)         tbl_frm_q <= '0;
        else if (cap_pde_i) tbl_frm_q <= entry_i[AW-1:OFF_W];
    end

    // translated address from a present table entry
    always_ff @(posedge clk) begin
        if (!rst_n)         phys_q <= '0;
        else if (cap_pte_i) phys_q <= {entry_i[AW-1:OFF_W], pg_off};
    end

    // faulting linear address
    always_ff @(posedge clk) begin
        if (!rst_n)         flt_q <= '0;
        else if (cap_flt_i) flt_q <= la_q;
    end

    assign phys_o     = phys_q;
    assign flt_addr_o = flt_q;
endmodule

// File: rtl/pgwalk.sv
// Two-level page walker top: sequencer plus datapath on one read port.
// Assumes: memory returns at most one valid word per issued read and only
// while the read request is high.
module pgwalk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DIR_W = 10,
    parameter int unsigned TBL_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] lin_addr_i,
    input  logic [AW-1:0] dir_base_i,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_rvalid_i,
    input  logic [AW-1:0] mem_rdata_i,
    output logic [AW-1:0] phys_addr_o,
    output logic          done_o,
    output logic          fault_o,
    output logic [AW-1:0] fault_addr_o
);
    logic sel_tbl;
    logic cap_req, cap_pde, cap_pte, cap_flt;

    pgwalk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .rvalid_i  (mem_rvalid_i),
        .present_i (mem_rdata_i[0]),
        .rd_o      (mem_rd_o),
        .sel_tbl_o (sel_tbl),
        .done_o    (done_o),
        .fault_o   (fault_o),
        .cap_req_o (cap_req),
        .cap_pde_o (cap_pde),
        .cap_pte_o (cap_pte),
        .cap_flt_o (cap_flt)
    );

    pgwalk_dpath #(.AW(AW), .DIR_W(DIR_W), .TBL_W(TBL_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .lin_i      (lin_addr_i),
        .dir_base_i (dir_base_i),
        .entry_i    (mem_rdata_i),
        .sel_tbl_i  (sel_tbl),
        .cap_req_i  (cap_req),
        .cap_pde_i  (cap_pde),
        .cap_pte_i  (cap_pte),
        .cap_flt_i  (cap_flt),
        .mem_addr_o (mem_addr_o),
        .phys_o     (phys_addr_o),
        .flt_addr_o (fault_addr_o)
    );
endmodule

// File: rtl/pgwalk_chk.sv
// Port-level property checker for the page walker, bound to every instance.
// Assumes: synchronous active-low reset.
module pgwalk_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rvalid_i,
    input logic [AW-1:0] phys_addr_o,
    input logic          done_o,
    input logic          fault_o,
    input logic [AW-1:0] fault_addr_o
);
    // R8: a pending read keeps its request and address
    a_r8_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    // R8: no read while a walk is reporting its end
    a_r8_no_read_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_rd_o);

    // R4: done lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a fault is always reported with done
    a_r5_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o);

    // R7: fault address moves only with a fault report
    a_r7_fault_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> $stable(fault_addr_o));

    // R7: physical address moves only with a successful completion
    a_r7_phys_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && !fault_o) |-> $stable(phys_addr_o));
endmodule

bind pgwalk pgwalk_chk #(.AW(AW)) u_pgwalk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .phys_addr_o  (phys_addr_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_addr_o (fault_addr_o)
);

// File: tb/test_pgwalk.sv
module test_pgwalk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] lin_addr_i = '0;
    logic [31:0] dir_base_i = '0;
    logic        mem_rd_o;
    logic [31:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic [31:0] phys_addr_o;
    logic        done_o;
    logic        fault_o;
    logic [31:0] fault_addr_o;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int rd_count = 0;
    logic [31:0] mem [logic [31:0]];

    always #2 clk = ~clk;

    pgwalk i_pgwalk (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .lin_addr_i(lin_addr_i),
        .dir_base_i(dir_base_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .phys_addr_o(phys_addr_o), .done_o(done_o), .fault_o(fault_o),
        .fault_addr_o(fault_addr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder: data valid after lat waiting cycles
    initial begin
        int wt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_rvalid_i = 1'b0; wt = 0;
            end else if (mem_rvalid_i) begin
                mem_rvalid_i = 1'b0; wt = 0;
            end else if (mem_rd_o) begin
                if (wt >= lat) begin
                    mem_rdata_i  = rdmem(mem_addr_o);
                    mem_rvalid_i = 1'b1;
                    rd_count++;
                end else wt++;
            end
        end
    end

    // behavioural reference model, advanced on each rising edge from inputs
    int          m_ph = 0;
    logic [31:0] m_la = '0, m_dir = '0, m_tbl = '0, m_pa = '0, m_cr2 = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pa = '0; m_cr2 = '0;
        end else begin
            case (m_ph)
                0: if (req_i) begin
                       m_la = lin_addr_i;
                       m_dir = (dir_base_i & 32'hFFFF_F000) + 32'(m_la >> 22) * 4;
                       m_ph = 1;
                   end
                1: if (mem_rvalid_i) begin
                       if (!mem_rdata_i[0]) begin m_cr2 = m_la; m_ph = 4; end
                       else begin
                           m_tbl = (mem_rdata_i & 32'hFFFF_F000) + ((m_la >> 12) & 32'h3FF) * 4;
                           m_ph = 2;
                       end
                   end
                2: if (mem_rvalid_i) begin
                       if (!mem_rdata_i[0]) begin m_cr2 = m_la; m_ph = 4; end
                       else begin
                           m_pa = (mem_rdata_i & 32'hFFFF_F000) | (m_la & 32'hFFF);
                           m_ph = 3;
                       end
                   end
                default: m_ph = 0;
            endcase
        end
    end

    // compare against the model every cycle, at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(mem_rd_o == (m_ph == 1 || m_ph == 2), "R8 read request", 32'(mem_rd_o), 32'(m_ph == 1 || m_ph == 2));
                if (m_ph == 1) chk(mem_addr_o == m_dir, "R2 directory entry address", mem_addr_o, m_dir);
                if (m_ph == 2) chk(mem_addr_o == m_tbl, "R3 table entry address", mem_addr_o, m_tbl);
                chk(done_o == (m_ph >= 3), "R4 done timing", 32'(done_o), 32'(m_ph >= 3));
                chk(fault_o == (m_ph == 4), "R5 fault timing", 32'(fault_o), 32'(m_ph == 4));
                chk(phys_addr_o == m_pa, "R7 physical address", phys_addr_o, m_pa);
                chk(fault_addr_o == m_cr2, "R7 fault address", fault_addr_o, m_cr2);
            end
        end
    end

    // one walk with a junk request during it (R9); checks final results
    task automatic walk(input logic [31:0] la, input logic [31:0] base, input int l,
                        input bit exp_flt, input logic [31:0] exp_pa, input int exp_rds, input string tag);
        int start;
        bit seen = 0;
        logic [31:0] pa_before, cr2_before;
        pa_before = phys_addr_o; cr2_before = fault_addr_o;
        lat = l;
        start = rd_count;
        @(negedge clk);
        req_i = 1'b1; lin_addr_i = la; dir_base_i = base;
        @(negedge clk);
        lin_addr_i = ~la; dir_base_i = base ^ 32'h0F0F_0000;
        @(negedge clk);
        req_i = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, {tag, " done seen"}, 32'(seen), 32'd1);
        chk(fault_o == exp_flt, {tag, " fault flag"}, 32'(fault_o), 32'(exp_flt));
        if (exp_flt) begin
            chk(fault_addr_o == la, {tag, " fault address"}, fault_addr_o, la);
            chk(phys_addr_o == pa_before, "R7 result held on fault", phys_addr_o, pa_before);
        end else begin
            chk(phys_addr_o == exp_pa, {tag, " physical address"}, phys_addr_o, exp_pa);
            chk(fault_addr_o == cr2_before, "R7 fault address held on success", fault_addr_o, cr2_before);
        end
        chk(rd_count - start == exp_rds, {tag, " read count"}, 32'(rd_count - start), 32'(exp_rds));
        @(negedge clk);
        @(negedge clk);
        chk(!mem_rd_o, "R9 no walk from request while busy", 32'(mem_rd_o), 32'd0);
    endtask

    initial begin
        // directory at 0x10000, table at 0x20000 / 0x30000
        mem[32'h0001_0004] = 32'h0002_0007;
        mem[32'h0002_000C] = 32'hABCD_E001;
        mem[32'h0002_0014] = 32'h1234_5FFE;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'h0000_1001;
        mem[32'h0001_0000] = 32'h0002_0003;
        mem[32'h0002_0000] = 32'h0000_0001;
        // second directory at 0x50000
        mem[32'h0005_0004] = 32'h0006_0001;
        mem[32'h0006_000C] = 32'h7777_7001;

        repeat (3) @(negedge clk);
        chk(!mem_rd_o && !done_o && !fault_o, "R1 reset controls", {29'd0, mem_rd_o, done_o, fault_o}, 32'd0);
        chk(phys_addr_o == 0 && fault_addr_o == 0, "R1 reset registers", phys_addr_o | fault_addr_o, 32'd0);
        rst_n = 1'b1;

        for (int l = 0; l < 4; l += (l == 1) ? 2 : 1) begin
            walk(32'h0040_3123, 32'h0001_0ABC, l, 0, 32'hABCD_E123, 2, "R4 success low bits of base ignored (R2)");
            walk(32'h0080_0456, 32'h0001_0000, l, 1, 32'h0, 1, "R5 directory entry absent");
            walk(32'h0040_5FFF, 32'h0001_0000, l, 1, 32'h0, 2, "R6 table entry absent");
            walk(32'hFFFF_FFFF, 32'h0001_0FFF, l, 0, 32'h0000_1FFF, 2, "R3 top indices");
            walk(32'h0040_3123, 32'h0005_0000, l, 0, 32'h7777_7123, 2, "R10 new base");
            walk(32'h0000_0ABC, 32'h0001_0000, l, 0, 32'h0000_0ABC, 2, "R4 zero indices");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: run not finished actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule